// File: doc/BRIEF.md
# Supply-Dip Reset Qualifier and Release Sequencer

This block produces the chip-wide reset from two sources: a brown-out comparator that flags a low supply, and an active-low external reset pin. A low-supply report becomes a reset only after it has stayed present without a break for longer than a programmable time window. Shorter dips are discarded and leave the block as it was. The qualified supply reset is ORed with the external pin. Once every source has gone quiet, the reset output is held for a fixed oscillator-settling count before the chip may run.

The block also owns an 8-bit control/status byte for a separate low-voltage detector. The byte holds a detector enable, a read-only detect flag, a 3-bit clock-select value and an oscillator start-mode flag. It also decides whether the shared voltage reference must be powered.

While the core is halted, both supply monitors are switched off. The analog comparators and the reference are outside the block. Here they appear only as digital inputs and enables.

Top module: `supply_reset_seq`

## Requirements
- R1: A supply reset is qualified only after the synchronized low-supply input has been sampled high on more than `CLKS_PER_MS` consecutive clocks, that is on `CLKS_PER_MS`+1 samples. A run of `CLKS_PER_MS` samples or fewer causes no reset, and the count restarts from zero whenever the input drops.
- R2: `sys_rst` is asserted (1) while the qualified supply reset is active or while the synchronized `ext_rst_n` is low. The two sources are ORed.
- R3: After all sources are inactive, `sys_rst` stays 1 for exactly `SETTLE_CYCLES` further clocks (default 1024) and then goes to 0.
- R4: While `halt` is 1, `lvr_enable` and `det_enable` are 0, the qualifier is cleared so that no supply reset can occur, and control bit 5 reads 0.
- R5: Control bit 3 turns the detector on when written 1 and off when written 0. This works only while `opt_det_en` is 1. With the option at 0, `det_enable` is 0 and bit 3 reads 0 whatever is written.
- R6: Control bit 5 is a read-only detect flag: it reads 1 when the detector is enabled and the synchronized `lvd_cmp` is 1. Bits 7:6 always read 0.
- R7: Control bits 2:0 (clock select) and bit 4 (oscillator start mode: 0 quick, 1 slow) store the written value and read it back. All stored control bits reset to 0 on `por_n`.
- R8: `ref_enable` is 1 whenever `det_enable` is 1. Otherwise it equals `opt_lvr_en`.
- R9: If any reset source re-asserts during the settling hold, the hold count restarts from zero once the sources clear again.
- R10: `ext_rst_n`, `low_supply` and `lvd_cmp` each pass through a two-flop synchronizer, so a change is seen by the logic two clocks later. `por_n` asynchronously sets `sys_rst` to 1.
- R11: With `opt_lvr_en` at 0, `lvr_enable` is 0 and a low-supply input of any length causes no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| low_supply | input | 1 | Brown-out comparator output, 1 = supply low |
| lvd_cmp | input | 1 | Low-voltage detector comparator output, 1 = low |
| halt | input | 1 | Core halted; switches both monitors off |
| opt_lvr_en | input | 1 | Configuration option enabling the supply-reset path |
| opt_det_en | input | 1 | Configuration option permitting the detector |
| ctrl_wr | input | 1 | Write strobe for the control byte |
| ctrl_wdata | input | 8 | Control byte write data |
| ctrl_rdata | output | 8 | Control byte read data |
| det_enable | output | 1 | Enable to the detector comparator |
| ref_enable | output | 1 | Enable to the voltage reference |
| lvr_enable | output | 1 | Enable to the brown-out comparator |
| sys_rst | output | 1 | Chip reset, active high |

## Verification
A wrong window count shows at `sys_rst` in two ways. Either a spurious reset rises about three clocks after a dip one sample too short ends, or a reset is missing after a dip one sample too long. Both are seen within a few clocks because the bench model is compared on every cycle. A wrong settling counter moves the falling edge of `sys_rst` away from clock 1024 after release, and a hold that fails to restart lets `sys_rst` drop early after an external pulse. Wrong stored control state appears on `ctrl_rdata` and the enables in the cycle after the write, or in the cycle `halt` or an option changes.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;

   // Bit positions of the control byte; software decodes these.
   localparam int CSEL_LSB   = 0;
   localparam int CSEL_W     = 3;
   localparam int DETON_BIT  = 3;
   localparam int SLOWSU_BIT = 4;
   localparam int DFLAG_BIT  = 5;

   typedef struct packed {
      logic [1:0] zero;
      logic       det_flag;
      logic       slow_start;
      logic       det_on;
      logic [2:0] clk_sel;
   } ctrl_byte_t;

   // Synchronizer lane assignment
   localparam int LANE_EXT = 0;
   localparam int LANE_LOW = 1;
   localparam int LANE_DET = 2;
   localparam int LANES    = 3;

endpackage

// File: rtl/supply_sync.sv
module supply_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("supply_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("supply_sync: WIDTH must be at least 1");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] r;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) r <= RST_VAL;
            else         r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) r <= RST_VAL;
            else         r <= g_stage[s-1].r;
         end
      end
   end

   assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/dip_filter.sv
module dip_filter #(
   parameter int WINDOW = 4000
) (
   input  logic clk,
   input  logic arst_n,
   input  logic enable,
   input  logic low_s,
   output logic qual
);

   if (WINDOW < 1) begin : g_bad_window
      $error("dip_filter: WINDOW must be at least 1");
   end

   localparam int CW = $clog2(WINDOW + 1);
   localparam logic [CW-1:0] LIMIT = CW'(WINDOW);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         run_cnt <= '0;
         qual    <= 1'b0;
      end else if (!enable || !low_s) begin
         run_cnt <= '0;
         qual    <= 1'b0;
      end else if (run_cnt == LIMIT) begin
         qual    <= 1'b1;
      end else begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   AST_QUAL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!arst_n)
      qual |-> $past(low_s) && $past(enable)); // R1
   AST_QUAL_DROPS_OFF: assert property (@(posedge clk) disable iff (!arst_n)
      !enable |=> !qual); // R4

endmodule

// File: rtl/settle_hold.sv
module settle_hold #(
   parameter int HOLD = 1024
) (
   input  logic clk,
   input  logic arst_n,
   input  logic src,
   output logic rst_out
);

   if (HOLD < 2) begin : g_bad_hold
      $error("settle_hold: HOLD must be at least 2");
   end

   localparam int HW = $clog2(HOLD);
   localparam logic [HW-1:0] LAST = HW'(HOLD - 1);

   logic [HW-1:0] hold_cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         hold_cnt <= '0;
         rst_out  <= 1'b1;
      end else if (src) begin
         hold_cnt <= '0;
         rst_out  <= 1'b1;
      end else if (rst_out) begin
         if (hold_cnt == LAST) rst_out  <= 1'b0;
         else                  hold_cnt <= hold_cnt + 1'b1;
      end
   end

   AST_SRC_HOLDS_RST: assert property (@(posedge clk) disable iff (!arst_n)
      src |=> rst_out); // R2
   AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(rst_out) |-> !$past(src)); // R3
   AST_RESTART_ON_SRC: assert property (@(posedge clk) disable iff (!arst_n)
      (rst_out && src) |=> rst_out); // R9

endmodule

// File: rtl/det_ctrl.sv
module det_ctrl
   import supply_reset_pkg::*;
(
   input  logic       clk,
   input  logic       arst_n,
   input  logic       opt_det,
   input  logic       opt_lvr,
   input  logic       halt,
   input  logic       wr,
   input  logic [7:0] wdata,
   input  logic       det_s,
   output logic [7:0] rdata,
   output logic       det_en,
   output logic       ref_en
);

   logic [CSEL_W-1:0] clk_sel_q;
   logic              det_on_q;
   logic              slow_q;
   logic              unused_wbits;
   ctrl_byte_t        view;

   assign unused_wbits = ^wdata[7:DFLAG_BIT];

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         clk_sel_q <= '0;
         det_on_q  <= 1'b0;
         slow_q    <= 1'b0;
      end else if (wr) begin
         clk_sel_q <= wdata[CSEL_LSB +: CSEL_W];
         det_on_q  <= wdata[DETON_BIT] & opt_det;
         slow_q    <= wdata[SLOWSU_BIT];
      end
   end

   always_comb begin
      det_en          = det_on_q & opt_det & ~halt;
      ref_en          = det_en | opt_lvr;
      view.zero       = 2'b00;
      view.det_flag   = det_en & det_s;
      view.slow_start = slow_q;
      view.det_on     = det_on_q & opt_det;
      view.clk_sel    = clk_sel_q;
      rdata           = view;
   end

   AST_OPT_GATES_DET: assert property (@(posedge clk) disable iff (!arst_n)
      !opt_det |-> !det_en && !rdata[DETON_BIT]); // R5
   AST_HALT_DET_OFF: assert property (@(posedge clk) disable iff (!arst_n)
      halt |-> !det_en && !rdata[DFLAG_BIT]); // R4
   AST_REF_WITH_DET: assert property (@(posedge clk) disable iff (!arst_n)
      det_en |-> ref_en); // R8

endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
   import supply_reset_pkg::*;
#(
   parameter int CLKS_PER_MS   = 4000,
   parameter int SETTLE_CYCLES = 1024,
   parameter int SYNC_STAGES   = 2
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       ext_rst_n,
   input  logic       low_supply,
   input  logic       lvd_cmp,
   input  logic       halt,
   input  logic       opt_lvr_en,
   input  logic       opt_det_en,
   input  logic       ctrl_wr,
   input  logic [7:0] ctrl_wdata,
   output logic [7:0] ctrl_rdata,
   output logic       det_enable,
   output logic       ref_enable,
   output logic       lvr_enable,
   output logic       sys_rst
);

   logic [LANES-1:0] raw_in;
   logic [LANES-1:0] syn_in;
   logic             ext_s_n;
   logic             low_s;
   logic             det_s;
   logic             supply_qual;
   logic             any_src;

   assign raw_in[LANE_EXT] = ext_rst_n;
   assign raw_in[LANE_LOW] = low_supply;
   assign raw_in[LANE_DET] = lvd_cmp;

   // External lane resets to 0, i.e. reset asserted.
   supply_sync #(
      .WIDTH  (LANES),
      .STAGES (SYNC_STAGES),
      .RST_VAL('0)
   ) i_sync (
      .clk   (clk),
      .arst_n(por_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign ext_s_n    = syn_in[LANE_EXT];
   assign low_s      = syn_in[LANE_LOW];
   assign det_s      = syn_in[LANE_DET];
   assign lvr_enable = opt_lvr_en & ~halt;

   dip_filter #(.WINDOW(CLKS_PER_MS)) i_dip (
      .clk   (clk),
      .arst_n(por_n),
      .enable(lvr_enable),
      .low_s (low_s),
      .qual  (supply_qual)
   );

   assign any_src = supply_qual | ~ext_s_n;

   settle_hold #(.HOLD(SETTLE_CYCLES)) i_hold (
      .clk    (clk),
      .arst_n (por_n),
      .src    (any_src),
      .rst_out(sys_rst)
   );

   det_ctrl i_ctrl (
      .clk    (clk),
      .arst_n (por_n),
      .opt_det(opt_det_en),
      .opt_lvr(opt_lvr_en),
      .halt   (halt),
      .wr     (ctrl_wr),
      .wdata  (ctrl_wdata),
      .det_s  (det_s),
      .rdata  (ctrl_rdata),
      .det_en (det_enable),
      .ref_en (ref_enable)
   );

   AST_EXT_FORCES_RST: assert property (@(posedge por_n ? clk : clk) disable iff (!por_n)
      !ext_s_n |=> sys_rst); // R2
   AST_NO_LVR_WHEN_OFF: assert property (@(posedge clk) disable iff (!por_n)
      !lvr_enable |=> !supply_qual); // R11
   AST_BITS_HIGH_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      ctrl_rdata[7:6] == 2'b00); // R6

endmodule

// File: tb/test_supply_reset_seq.sv
module test_supply_reset_seq;

   localparam int W = 40;
   localparam int H = 1024;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       ext_rst_n = 1'b1;
   logic       low_supply = 1'b0;
   logic       lvd_cmp = 1'b0;
   logic       halt = 1'b0;
   logic       opt_lvr_en = 1'b1;
   logic       opt_det_en = 1'b1;
   logic       ctrl_wr = 1'b0;
   logic [7:0] ctrl_wdata = 8'h00;
   logic [7:0] ctrl_rdata;
   logic       det_enable, ref_enable, lvr_enable, sys_rst;

   int total = 0;
   int fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   supply_reset_seq #(.CLKS_PER_MS(W), .SETTLE_CYCLES(H)) i_supply_reset_seq (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .low_supply(low_supply),
      .lvd_cmp(lvd_cmp), .halt(halt), .opt_lvr_en(opt_lvr_en), .opt_det_en(opt_det_en),
      .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
      .det_enable(det_enable), .ref_enable(ref_enable), .lvr_enable(lvr_enable),
      .sys_rst(sys_rst)
   );

   // Behavioural reference model
   bit e0, e1, l0, l1, d0, d1;
   int run, hcnt;
   bit qual, mrst, m_on, m_slow;
   bit [2:0] m_sel;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         e0 = 0; e1 = 0; l0 = 0; l1 = 0; d0 = 0; d1 = 0;
         run = 0; hcnt = 0; qual = 0; mrst = 1;
         m_on = 0; m_slow = 0; m_sel = 0;
      end else begin
         if (qual || !e1) begin
            hcnt = 0; mrst = 1;
         end else if (mrst) begin
            if (hcnt == H - 1) mrst = 0;
            else hcnt++;
         end
         if (!(opt_lvr_en && !halt) || !l1) begin
            run = 0; qual = 0;
         end else if (run == W) qual = 1;
         else run++;
         if (ctrl_wr) begin
            m_sel = ctrl_wdata[2:0];
            m_on = ctrl_wdata[3] && opt_det_en;
            m_slow = ctrl_wdata[4];
         end
         e1 = e0; e0 = ext_rst_n;
         l1 = l0; l0 = low_supply;
         d1 = d0; d0 = lvd_cmp;
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Per-cycle comparison, away from the clock edge
   always begin
      @(posedge clk);
      #5;
      if (por_n && !done) begin
         bit x_det;
         bit [7:0] x_rd;
         x_det = m_on && opt_det_en && !halt;
         x_rd = {2'b00, x_det && d1, m_slow, m_on && opt_det_en, m_sel};
         chk("R3 sys_rst model", {7'd0, sys_rst}, {7'd0, mrst});
         chk("R5 det_enable model", {7'd0, det_enable}, {7'd0, x_det});
         chk("R8 ref_enable model", {7'd0, ref_enable}, {7'd0, x_det || opt_lvr_en});
         chk("R4 lvr_enable model", {7'd0, lvr_enable}, {7'd0, opt_lvr_en && !halt});
         chk("R7 ctrl_rdata model", ctrl_rdata, x_rd);
      end
   end

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] v);
      ctrl_wr = 1'b1; ctrl_wdata = v;
      cyc(1);
      ctrl_wr = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      total++; fails++;
      $display("FAIL watchdog expired");
      done = 1;
      summary();
      $finish;
   end

   initial begin
      cyc(3);
      chk("R10 sys_rst during por", {7'd0, sys_rst}, 8'd1);
      chk("R7 rdata reset", ctrl_rdata, 8'h00);
      por_n = 1'b1;
      cyc(H + 1);
      chk("R3 still held at 1025", {7'd0, sys_rst}, 8'd1);
      cyc(1);
      chk("R3 released at 1026", {7'd0, sys_rst}, 8'd0);

      // control byte
      wr(8'hFF);
      chk("R7 R6 readback", ctrl_rdata, 8'h1F);
      chk("R5 det on", {7'd0, det_enable}, 8'd1);
      lvd_cmp = 1'b1;
      cyc(2);
      chk("R6 flag after sync", ctrl_rdata, 8'h3F);
      halt = 1'b1;
      cyc(1);
      chk("R4 halt det off", {6'd0, det_enable, lvr_enable}, 8'd0);
      chk("R4 halt flag", ctrl_rdata, 8'h1F);
      low_supply = 1'b1;
      cyc(3 * W);
      chk("R4 halt no reset", {7'd0, sys_rst}, 8'd0);
      low_supply = 1'b0;
      halt = 1'b0;
      cyc(3);
      opt_det_en = 1'b0;
      wr(8'h0A);
      chk("R5 option clear", ctrl_rdata, 8'h02);
      chk("R5 det off", {7'd0, det_enable}, 8'd0);
      chk("R8 ref follows lvr opt", {7'd0, ref_enable}, 8'd1);
      opt_lvr_en = 1'b0;
      cyc(1);
      chk("R8 ref off", {7'd0, ref_enable}, 8'd0);
      low_supply = 1'b1;
      cyc(3 * W);
      low_supply = 1'b0;
      chk("R11 no reset with option off", {7'd0, sys_rst}, 8'd0);
      opt_lvr_en = 1'b1;
      opt_det_en = 1'b1;
      lvd_cmp = 1'b0;
      cyc(3);

      // dip just under the window
      low_supply = 1'b1;
      cyc(W);
      low_supply = 1'b0;
      cyc(10);
      chk("R1 short dip ignored", {7'd0, sys_rst}, 8'd0);
      // dip just over the window
      low_supply = 1'b1;
      cyc(W + 1);
      low_supply = 1'b0;
      cyc(4);
      chk("R1 long dip resets", {7'd0, sys_rst}, 8'd1);
      cyc(H - 50);
      ext_rst_n = 1'b0;
      cyc(2);
      ext_rst_n = 1'b1;
      cyc(60);
      chk("R9 hold restarted", {7'd0, sys_rst}, 8'd1);
      cyc(H);
      chk("R9 released after restart", {7'd0, sys_rst}, 8'd0);

      // external reset alone
      ext_rst_n = 1'b0;
      cyc(4);
      chk("R2 ext reset asserts", {7'd0, sys_rst}, 8'd1);
      ext_rst_n = 1'b1;
      cyc(H + 10);
      chk("R2 ext reset released", {7'd0, sys_rst}, 8'd0);

      done = 1;
      cyc(1);
      summary();
      $finish;
   end

endmodule